// File: doc/BRIEF.md
# FM Synthesizer Dual Interval Timers

This block provides the two interval timers of an FM sound generator. Software programs it with byte-wide register writes. Timer A takes a 10-bit reload value, split between a high-part register and a low-part register. Timer B takes an 8-bit value and counts in units of a power-of-two number of base ticks. Both timers count down on a shared base tick strobe. Each timer can set a sticky overflow flag, and the two flags are ORed onto one interrupt output. Once started, a timer reloads itself after every overflow.

The control register carries the operating mode of the third channel in its top two bits. In the composite-sine mode (mode code 2), every timer A overflow keys on that channel's operators. The block shows this as a one-cycle pulse and as a held key level. A control write that takes the mode out of composite-sine releases the held key. Any control write that changes the mode bits raises a one-cycle request, so that the channel's phase increments are recomputed.

Each timer is a two-state machine, held in the state enumeration `tmr_state_e`. The transition TMR_IDLE → TMR_RUN (*start*) is taken when its load bit becomes 1, and it loads the full period. The transition TMR_RUN → TMR_RUN (*wrap*) is taken on the tick that ends a period, and it reloads the period. The transition TMR_RUN → TMR_IDLE (*halt*) is taken when the load bit is 0. The key-on tracker has two states, held in the enumeration `key_state_e`. The transition KEY_IDLE → KEY_HELD (*strike*) is taken on a timer A overflow in composite-sine mode. The transition KEY_HELD → KEY_IDLE (*release*) is taken on a control write that leaves composite-sine mode.

Top module: `fm_interval_timers`

## Requirements
- R1: After reset, all outputs are 0, the mode is 0, both timers are stopped, and both timer values are 0.
- R2: A write to address 0x24 sets timer A value bits 9:2 from the data. A write to 0x25 sets bits 1:0 from data bits 1:0. Each of these writes keeps the other part of the value.
- R3: Timer A counts only on cycles where `tick` is 1. Its flag rises exactly (1024 − TA) ticks after the control write that starts it.
- R4: Address 0x26 holds TB. Timer B's flag rises (256 − TB) × 2^B_DIV_LOG2 ticks after its start.
- R5: A running timer reloads itself at each overflow, so successive timer A overflows are (1024 − TA) ticks apart.
- R6: In the control register at 0x27, bit 0 runs timer A and bit 1 runs timer B. A 0→1 change starts the timer with a full period, and a 0 stops it. Bit 2 enables flag A and bit 3 enables flag B. Writing 1 to bit 4 clears flag A, and writing 1 to bit 5 clears flag B.
- R7: An overflow sets a flag only when that flag is enabled. `irq` is 1 exactly when at least one flag is set.
- R8: `ch3_mode` shows control bits 7:6. A control write that changes them produces a one-cycle pulse on `ch3_recalc`. A write that keeps them produces no pulse.
- R9: In mode 2, each timer A overflow gives a one-cycle `csm_key_pulse`, and `csm_key_on` is then held at 1.
- R10: A control write to a mode other than 2 clears `csm_key_on` at once. In modes other than 2, no key pulses occur.
- R11: A timer B overflow never produces a key pulse and never sets the key level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address (0x24–0x27) |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Base tick strobe that advances the timers |
| flag_a | output | 1 | Timer A overflow flag |
| flag_b | output | 1 | Timer B overflow flag |
| irq | output | 1 | OR of both flags |
| ch3_mode | output | 2 | Current third-channel mode |
| ch3_recalc | output | 1 | One-cycle request to recompute the channel's phase increments |
| csm_key_pulse | output | 1 | One-cycle key-on pulse on timer A overflow in mode 2 |
| csm_key_on | output | 1 | Held key-on level set by timer-driven keying |

## Verification
The bench builds the block with B_DIV_LOG2 = 2, so each timer B step lasts four ticks instead of sixteen. The A and B widths stay at their defaults. With this setting, a sweep of the 32 largest TB values and the TB = 0 extreme fits in a short run. Timer A keeps its full 10-bit value and is swept over its 64 shortest periods, plus TA = 0 and a mid value. The period is measured to the exact cycle each time, along with reload spacing, a stalled tick and a half-rate tick.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    localparam logic [7:0] ADDR_TA_HI = 8'h24;
    localparam logic [7:0] ADDR_TA_LO = 8'h25;
    localparam logic [7:0] ADDR_TB    = 8'h26;
    localparam logic [7:0] ADDR_CTRL  = 8'h27;

    localparam logic [1:0] MODE_CSM   = 2'd2;

    typedef enum logic { TMR_IDLE, TMR_RUN } tmr_state_e;
    typedef enum logic { KEY_IDLE, KEY_HELD } key_state_e;

    // Field layout of the control byte (bit positions matter to software)
    typedef struct packed {
        logic [1:0] mode;   // 7:6
        logic       clr_b;  // 5
        logic       clr_a;  // 4
        logic       en_b;   // 3
        logic       en_a;   // 2
        logic       run_b;  // 1
        logic       run_a;  // 0
    } ctrl_t;

endpackage

// File: rtl/fmt_regs.sv
module fmt_regs
    import fmt_pkg::*;
#(
    parameter int A_HI_W = 8,
    parameter int A_LO_W = 2,
    parameter int B_W    = 8,
    localparam int A_W   = A_HI_W + A_LO_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [7:0]     wr_addr,
    input  logic [7:0]     wr_data,
    output logic [A_W-1:0] ta_val,
    output logic [B_W-1:0] tb_val,
    output ctrl_t          ctrl_q,
    output ctrl_t          ctrl_in,
    output logic           ctrl_wr
);

    logic hi_wr, lo_wr, b_wr;

    always_comb begin
        hi_wr   = wr_en && (wr_addr == ADDR_TA_HI);
        lo_wr   = wr_en && (wr_addr == ADDR_TA_LO);
        b_wr    = wr_en && (wr_addr == ADDR_TB);
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
        ctrl_in = ctrl_t'(wr_data);
    end

    // Timer A value: two independently written parts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ta_val <= '0;
        end else begin
            if (hi_wr) ta_val[A_W-1:A_LO_W] <= wr_data[A_HI_W-1:0];
            if (lo_wr) ta_val[A_LO_W-1:0]   <= wr_data[A_LO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tb_val <= '0;
        else if (b_wr) tb_val <= wr_data[B_W-1:0];
    end

    // Control: clear bits are strobes and are never stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q       <= ctrl_in;
            ctrl_q.clr_a <= 1'b0;
            ctrl_q.clr_b <= 1'b0;
        end
    end

endmodule

// File: rtl/fmt_down_timer.sv
module fmt_down_timer
    import fmt_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic [CNT_W-1:0] period,
    output logic             ovf,
    output logic             running
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: start / wrap / halt
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (run_en) begin
                    state_d = TMR_RUN;
                    cnt_d   = period;
                end
            end
            TMR_RUN: begin
                if (!run_en) begin
                    state_d = TMR_IDLE;
                end else if (tick) begin
                    if (cnt_q == CNT_ONE) cnt_d = period;
                    else                  cnt_d = cnt_q - CNT_ONE;
                end
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        running = (state_q == TMR_RUN);
        ovf     = running && run_en && tick && (cnt_q == CNT_ONE);
    end

endmodule

// File: rtl/fmt_flags.sv
module fmt_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ovf,
    input  logic [N-1:0] en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                flag[i] <= 1'b0;
            else if (clr[i])           flag[i] <= 1'b0;
            else if (ovf[i] && en[i])  flag[i] <= 1'b1;
        end
    end

    always_comb irq = |flag;

endmodule

// File: rtl/fmt_csm_key.sv
module fmt_csm_key
    import fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_a,
    input  logic [1:0] mode_q,
    input  logic       ctrl_wr,
    input  logic [1:0] mode_in,
    output logic       key_pulse,
    output logic       key_on,
    output logic       recalc
);

    key_state_e state_q, state_d;
    logic       leave, strike;

    always_comb begin
        leave  = ctrl_wr && (mode_in != MODE_CSM);
        strike = ovf_a && (mode_q == MODE_CSM) && !leave;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    // Next state: strike / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: if (strike) state_d = KEY_HELD;
            KEY_HELD: if (leave)  state_d = KEY_IDLE;
            default:              state_d = KEY_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_pulse <= 1'b0;
            recalc    <= 1'b0;
        end else begin
            key_pulse <= strike;
            recalc    <= ctrl_wr && (mode_in != mode_q);
        end
    end

    always_comb key_on = (state_q == KEY_HELD);

endmodule

// File: rtl/fm_interval_timers.sv
module fm_interval_timers
    import fmt_pkg::*;
#(
    parameter int A_HI_W     = 8,
    parameter int A_LO_W     = 2,
    parameter int B_W        = 8,
    parameter int B_DIV_LOG2 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       tick,
    output logic       flag_a,
    output logic       flag_b,
    output logic       irq,
    output logic [1:0] ch3_mode,
    output logic       ch3_recalc,
    output logic       csm_key_pulse,
    output logic       csm_key_on
);

    localparam int A_W     = A_HI_W + A_LO_W;
    localparam int A_CNT_W = A_W + 1;
    localparam int B_CNT_W = B_W + 1 + B_DIV_LOG2;

    logic [A_W-1:0]     ta_val;
    logic [B_W-1:0]     tb_val;
    ctrl_t              ctrl_q, ctrl_in;
    logic               ctrl_wr;
    logic [A_CNT_W-1:0] period_a;
    logic [B_CNT_W-1:0] period_b;
    logic               run_a, run_b, en_a, en_b;
    logic               ovf_a, ovf_b, busy_a, busy_b;
    logic [1:0]         flags;

    fmt_regs #(.A_HI_W(A_HI_W), .A_LO_W(A_LO_W), .B_W(B_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ta_val(ta_val), .tb_val(tb_val),
        .ctrl_q(ctrl_q), .ctrl_in(ctrl_in), .ctrl_wr(ctrl_wr)
    );

    always_comb begin
        period_a = A_CNT_W'(1 << A_W) - A_CNT_W'(ta_val);
        period_b = (B_CNT_W'(1 << B_W) - B_CNT_W'(tb_val)) << B_DIV_LOG2;
        run_a    = ctrl_wr ? ctrl_in.run_a : ctrl_q.run_a;
        run_b    = ctrl_wr ? ctrl_in.run_b : ctrl_q.run_b;
        en_a     = ctrl_q.en_a;
        en_b     = ctrl_q.en_b;
        ch3_mode = ctrl_q.mode;
    end

    fmt_down_timer #(.CNT_W(A_CNT_W)) u_tmr_a (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_a),
        .period(period_a), .ovf(ovf_a), .running(busy_a)
    );

    fmt_down_timer #(.CNT_W(B_CNT_W)) u_tmr_b (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_b),
        .period(period_b), .ovf(ovf_b), .running(busy_b)
    );

    fmt_flags #(.N(2)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .ovf({ovf_b, ovf_a}),
        .en({en_b, en_a}),
        .clr({ctrl_wr && ctrl_in.clr_b, ctrl_wr && ctrl_in.clr_a}),
        .flag(flags), .irq(irq)
    );

    always_comb begin
        flag_a = flags[0];
        flag_b = flags[1];
    end

    fmt_csm_key u_key (
        .clk(clk), .rst_n(rst_n), .ovf_a(ovf_a), .mode_q(ctrl_q.mode),
        .ctrl_wr(ctrl_wr), .mode_in(ctrl_in.mode),
        .key_pulse(csm_key_pulse), .key_on(csm_key_on), .recalc(ch3_recalc)
    );

endmodule

// File: rtl/fmt_timers_checker.sv
module fmt_timers_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       flag_a,
    input logic       flag_b,
    input logic       irq,
    input logic [1:0] ch3_mode,
    input logic       ch3_recalc,
    input logic       csm_key_pulse,
    input logic       csm_key_on,
    input logic       en_a,
    input logic       en_b
);

    assert_flag_a_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a) |-> $past(en_a));

    assert_flag_b_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_b) |-> $past(en_b));

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(flag_a) || $rose(flag_b)));

    assert_recalc_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ch3_recalc |-> (ch3_mode != $past(ch3_mode)));

    assert_pulse_in_csm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        csm_key_pulse |-> ($past(ch3_mode == 2'd2) && csm_key_on));

    assert_key_needs_csm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        csm_key_on |-> (ch3_mode == 2'd2));

endmodule

bind fm_interval_timers fmt_timers_checker u_chk (
    .clk(clk), .rst_n(rst_n), .flag_a(flag_a), .flag_b(flag_b), .irq(irq),
    .ch3_mode(ch3_mode), .ch3_recalc(ch3_recalc),
    .csm_key_pulse(csm_key_pulse), .csm_key_on(csm_key_on),
    .en_a(en_a), .en_b(en_b)
);

// File: tb/fm_interval_timers_test.sv
`timescale 1ns/1ps
module fm_interval_timers_test;

    localparam int DIV_LOG2 = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b1;
    int         tick_mode = 0;   // 0 always, 1 never, 2 alternate
    logic       flag_a, flag_b, irq, ch3_recalc, csm_key_pulse, csm_key_on;
    logic [1:0] ch3_mode;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (tick_mode == 0)      tick <= 1'b1;
        else if (tick_mode == 1) tick <= 1'b0;
        else                     tick <= ~tick;
    end

    fm_interval_timers #(.B_DIV_LOG2(DIV_LOG2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .flag_a(flag_a), .flag_b(flag_b),
        .irq(irq), .ch3_mode(ch3_mode), .ch3_recalc(ch3_recalc),
        .csm_key_pulse(csm_key_pulse), .csm_key_on(csm_key_on)
    );

    task automatic check(input int act, input int exp, input string req);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_a(output int n);
        n = 0;
        while (!flag_a && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_b(output int n);
        n = 0;
        while (!flag_b && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!csm_key_pulse && n < 5000);
    endtask

    task automatic set_ta(input int ta);
        wr(8'h24, 8'(ta >> 2));
        wr(8'h25, 8'(ta & 3));
    endtask

    task automatic run_a(input int exp, input string req);
        int n;
        wr(8'h27, 8'h10);
        wr(8'h27, 8'h05);
        wait_a(n);
        check(n, exp, req);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #1_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int n, cnt;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({flag_a, flag_b, irq, ch3_recalc, csm_key_pulse, csm_key_on}, 0, "R1 outputs");
        check(ch3_mode, 0, "R1 mode");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: TA=0 after reset -> 1024 ticks
        run_a(1024, "R1/R3 reset TA");

        // R3 sweep of the 64 shortest periods
        for (int ta = 1023; ta >= 960; ta--) begin
            set_ta(ta);
            run_a(1024 - ta, "R3 sweep");
        end
        set_ta(512);
        run_a(512, "R3 mid");

        // R2 partial writes keep the other part
        set_ta(1021);
        wr(8'h24, 8'hFE);
        run_a(7, "R2 hi only");
        wr(8'h25, 8'h03);
        run_a(5, "R2 lo only");
        check(irq, 1, "R7 irq from A");

        // R6 clear bit
        wr(8'h27, 8'h10);
        check(flag_a, 0, "R6 clear A");
        check(irq, 0, "R7 irq idle");

        // R3 stalled tick
        tick_mode = 1;
        wr(8'h27, 8'h05);
        repeat (20) @(negedge clk);
        check(flag_a, 0, "R3 no tick no count");
        tick_mode = 2;
        wait_a(n);
        check(int'(n >= 9 && n <= 10), 1, "R3 half-rate tick");
        tick_mode = 0;

        // R6 stop then restart gives a full period
        wr(8'h27, 8'h10);
        wr(8'h27, 8'h05);
        repeat (2) @(negedge clk);
        wr(8'h27, 8'h04);
        repeat (12) @(negedge clk);
        check(flag_a, 0, "R6 stopped timer");
        wr(8'h27, 8'h05);
        wait_a(n);
        check(n, 5, "R6 restart full period");

        // R7 disabled flag stays low
        wr(8'h27, 8'h10);
        wr(8'h27, 8'h01);
        repeat (15) @(negedge clk);
        check(flag_a, 0, "R7 disabled flag");
        check(irq, 0, "R7 irq disabled");

        // R4 timer B sweep
        for (int tb = 255; tb >= 224; tb--) begin
            wr(8'h27, 8'h30);
            wr(8'h26, 8'(tb));
            wr(8'h27, 8'h0A);
            wait_b(n);
            check(n, (256 - tb) << DIV_LOG2, "R4 sweep");
        end
        wr(8'h27, 8'h30);
        wr(8'h26, 8'h00);
        wr(8'h27, 8'h0A);
        wait_b(n);
        check(n, 256 << DIV_LOG2, "R4 TB=0");
        check(irq, 1, "R7 irq from B");
        check(flag_a, 0, "R7 B only");

        // R11 timer B in CSM mode gives no key
        wr(8'h26, 8'hFF);
        wr(8'h27, 8'hBA);
        check(ch3_recalc, 1, "R8 change pulse");
        @(negedge clk);
        check(ch3_recalc, 0, "R8 one cycle");
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (csm_key_pulse || csm_key_on) cnt++;
        end
        check(cnt, 0, "R11 no key from B");
        wr(8'h27, 8'hB0);
        check(ch3_recalc, 0, "R8 same mode no pulse");

        // R9 / R5 CSM keying with TA=1019 (5 ticks)
        wr(8'h27, 8'hB5);
        wait_pulse(n);
        check(n, 5, "R9 first key pulse");
        check(csm_key_on, 1, "R9 key held");
        wait_pulse(n);
        check(n, 5, "R5 reload spacing");
        @(negedge clk);
        check(csm_key_pulse, 0, "R9 pulse one cycle");
        check(flag_a, 1, "R9 flag too");

        // R10 leaving CSM releases the key
        wr(8'h27, 8'h05);
        check(csm_key_on, 0, "R10 release");
        check(ch3_recalc, 1, "R8 leave pulse");
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (csm_key_pulse || csm_key_on) cnt++;
        end
        check(cnt, 0, "R10 mode 0 no keying");
        wr(8'h27, 8'h45);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (csm_key_pulse || csm_key_on) cnt++;
        end
        check(cnt, 0, "R10 mode 1 no keying");
        check(ch3_mode, 1, "R8 mode shown");

        summary();
        $finish;
    end

endmodule